// File: doc/BRIEF.md
# Interrupt Status Aggregator with Read-to-Clear Sources

This block gathers the twelve event sources of a two-wire serial bus controller into one interrupt line. Ten of the sources arrive as one-cycle pulses and latch sticky bits in a raw status vector. The two FIFO-threshold sources (receive full and transmit empty) are levels, and their raw bits follow the condition. A software-written enable vector selects which raw bits reach the masked status view and the interrupt output.

Software acknowledges a source by reading a register. Each source has its own acknowledge register, which clears only that source's bit. One combined acknowledge register clears every sticky bit at once. A read of any acknowledge register returns the state before the clear, so a handler can read and acknowledge in one access. When a transmit abort occurs, the block stores the cause vector that comes with it. The cause stays in place until the abort source is acknowledged.

Top module: `intr_agg_top`

## Requirements
- R1: A pulse on `srcEvt[i]` sets raw bit i at the next clock edge for every sticky source (all bits except 2 and 4). The bit stays set until it is acknowledged. Bit meanings: 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Reading word 0 returns the raw vector in bits 11:0.
- R2: A write to word 1 loads the enable vector from `busWdata[11:0]`. Writes to any other word change nothing. Reading word 1 returns the enable vector.
- R3: Reading word 2 always returns the raw vector ANDed with the enable vector.
- R4: Reading word 5+i (i = 0..11) returns raw bit i in bit 0 and clears only raw bit i.
- R5: Reading word 4 returns, in bit 0, the OR of all sticky raw bits, and clears all of them.
- R6: When an event pulse and an acknowledge read of the same source fall in the same cycle, the raw bit stays set.
- R7: Raw bits 2 (rx full) and 4 (tx empty) take the value of `srcEvt[2]` and `srcEvt[4]` at each edge. Acknowledge reads have no lasting effect on them.
- R8: On a tx-abort pulse (`srcEvt[6]`), `abortCause` is ORed into the abort reason register, read at word 3 in bits 12:0. Bit meanings: 0 7-bit address nack, 1 first 10-bit address byte nack, 2 second 10-bit address byte nack, 3 data nack, 4 general call nack, 5 read after general call, 7 start byte acked, 9 start byte with restart off, 10 10-bit read with restart off, 11 used while disabled, 12 arbitration lost. Between abort pulses and abort acknowledges, the register holds its value.
- R9: Reading word 11 (the abort acknowledge) or word 4 clears the abort reason. If an abort pulse arrives in the same cycle, the reason becomes that pulse's cause alone.
- R10: `irq` is a register that holds the OR of the masked status, as it stood in the cycle before.
- R11: After reset, the raw vector, the enable vector, the abort reason and `irq` are all zero. Reads of unmapped words (17 and up) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcEvt | input | 12 | Source events: pulses, except bits 2 and 4, which are levels |
| abortCause | input | 13 | Abort cause vector, sampled with the abort pulse |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during the read cycle |
| irq | output | 1 | Interrupt request |

## Verification
A raw bit that fails to latch or fails to clear shows up at the next read of word 0, word 2 or its acknowledge word. It also shows up in `irq` one cycle later, whenever that source is enabled. A lost or stale abort reason shows up at the next read of word 3. For this reason the stimulus mixes random acknowledge reads with status reads taken every few cycles, and it compares `irq` after every edge. The same-cycle collisions of event and acknowledge are directed cases, because on a broken design they leave a bit silently lost. A random run hits them rarely.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int SRC_N     = 12;
  localparam int REASON_W  = 13;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = $clog2(SRC_N);
  localparam int ABORT_IDX = 6;
  localparam int RXFULL_IDX  = 2;
  localparam int TXEMPTY_IDX = 4;

  // sources that mirror a level rather than latch a pulse
  localparam logic [SRC_N-1:0] LEVEL_MASK =
    (SRC_N'(1) << RXFULL_IDX) | (SRC_N'(1) << TXEMPTY_IDX);

  localparam logic [ADDR_W-1:0] ADR_RAW      = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_ENABLE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_MASKED   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_REASON   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_ACK_ALL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADR_ACK_BASE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] ADR_ACK_END  = ADDR_W'(5 + SRC_N);

  typedef enum logic [2:0] {
    RD_NONE, RD_RAW, RD_ENABLE, RD_MASKED, RD_REASON, RD_ACK_ALL, RD_ACK_ONE
  } rdKind_t;

  typedef struct packed {
    logic [SRC_N-1:0] clrVec;
    logic             enableWe;
    rdKind_t          rdKind;
    logic [IDX_W-1:0] srcIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/intr_agg_ctrl.sv
module intr_agg_ctrl
  import intr_agg_pkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  logic [ADDR_W-1:0] ackOffset;
  logic              inAckRange;

  assign ackOffset  = busAddr - ADR_ACK_BASE;
  assign inAckRange = (busAddr >= ADR_ACK_BASE) && (busAddr < ADR_ACK_END);

  always_comb begin
    strobe          = '0;
    strobe.rdKind   = RD_NONE;
    strobe.enableWe = busWr && (busAddr == ADR_ENABLE);
    if (busRd) begin
      if (busAddr == ADR_RAW)         strobe.rdKind = RD_RAW;
      else if (busAddr == ADR_ENABLE) strobe.rdKind = RD_ENABLE;
      else if (busAddr == ADR_MASKED) strobe.rdKind = RD_MASKED;
      else if (busAddr == ADR_REASON) strobe.rdKind = RD_REASON;
      else if (busAddr == ADR_ACK_ALL) begin
        strobe.rdKind = RD_ACK_ALL;
        strobe.clrVec = '1;
      end else if (inAckRange) begin
        strobe.rdKind = RD_ACK_ONE;
        strobe.srcIdx = IDX_W'(ackOffset);
        strobe.clrVec = SRC_N'(1) << ackOffset;
      end
    end
  end
endmodule

// File: rtl/intr_agg_datapath.sv
module intr_agg_datapath
  import intr_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [SRC_N-1:0]    srcEvt,
  input  logic [REASON_W-1:0] abortCause,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   rdData,
  output logic                irq
);
  logic [SRC_N-1:0]    rawStat;
  logic [SRC_N-1:0]    enableReg;
  logic [SRC_N-1:0]    maskedStat;
  logic [REASON_W-1:0] reasonReg;

  assign maskedStat = rawStat & enableReg;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rawStat[i] <= 1'b0;
        else       rawStat[i] <= srcEvt[i];
      end
    end else begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rawStat[i] <= 1'b0;
        else       rawStat[i] <= srcEvt[i] | (rawStat[i] & ~strobe.clrVec[i]);
      end

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        srcEvt[i] |=> rawStat[i]);
      // R4
      ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.clrVec[i] && !srcEvt[i]) |=> !rawStat[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enableReg <= '0;
    else if (strobe.enableWe)  enableReg <= busWdata[SRC_N-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reasonReg <= '0;
    end else if (srcEvt[ABORT_IDX]) begin
      reasonReg <= (strobe.clrVec[ABORT_IDX] ? '0 : reasonReg) | abortCause;
    end else if (strobe.clrVec[ABORT_IDX]) begin
      reasonReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |maskedStat;
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdKind)
      RD_RAW:     rdData[SRC_N-1:0]    = rawStat;
      RD_ENABLE:  rdData[SRC_N-1:0]    = enableReg;
      RD_MASKED:  rdData[SRC_N-1:0]    = maskedStat;
      RD_REASON:  rdData[REASON_W-1:0] = reasonReg;
      RD_ACK_ALL: rdData[0]            = |(rawStat & ~LEVEL_MASK);
      RD_ACK_ONE: rdData[0]            = rawStat[strobe.srcIdx];
      default:    rdData               = '0;
    endcase
  end

  // R9
  reason_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrVec[ABORT_IDX] && !srcEvt[ABORT_IDX]) |=> (reasonReg == '0));
  // R8
  reason_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcEvt[ABORT_IDX] && !strobe.clrVec[ABORT_IDX]) |=> $stable(reasonReg));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |=> !irq);
  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enableWe |=> $stable(enableReg));
endmodule

// File: rtl/intr_agg_top.sv
module intr_agg_top
  import intr_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SRC_N-1:0]    srcEvt,
  input  logic [REASON_W-1:0] abortCause,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irq
);
  ctrlStrobe_t strobe;

  intr_agg_ctrl i_ctrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  intr_agg_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcEvt     (srcEvt),
    .abortCause (abortCause),
    .busWdata   (busWdata),
    .rdData     (busRdata),
    .irq        (irq)
  );
endmodule

// File: tb/test_intr_agg_top.sv
`timescale 1ns/1ps
module test_intr_agg_top;
  localparam logic [11:0] LVL = 12'h014;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] srcEvt = '0;
  logic [12:0] abortCause = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [11:0] rawM = '0;
  logic [11:0] maskM = '0;
  logic [12:0] reasonM = '0;
  logic        irqM = 1'b0;

  always #2.5 clk = ~clk;

  intr_agg_top i_intr_agg_top (
    .clk(clk), .rstN(rstN), .srcEvt(srcEvt), .abortCause(abortCause),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  function automatic logic [31:0] expRead(input logic [4:0] a);
    logic [31:0] v = '0;
    if (a == 5'd0)      v[11:0] = rawM;
    else if (a == 5'd1) v[11:0] = maskM;
    else if (a == 5'd2) v[11:0] = rawM & maskM;
    else if (a == 5'd3) v[12:0] = reasonM;
    else if (a == 5'd4) v[0]    = |(rawM & ~LVL);
    else if (a >= 5'd5 && a < 5'd17) v[0] = rawM[a - 5'd5];
    return v;
  endfunction

  function automatic logic [11:0] clrOf(input logic rd, input logic [4:0] a);
    if (!rd) return '0;
    if (a == 5'd4) return 12'hFFF;
    if (a >= 5'd5 && a < 5'd17) return 12'd1 << (a - 5'd5);
    return '0;
  endfunction

  function automatic string tagOf(input logic [4:0] a);
    if (a == 5'd0) return "R1";
    if (a == 5'd1) return "R2";
    if (a == 5'd2) return "R3";
    if (a == 5'd3) return "R8";
    if (a == 5'd4) return "R5";
    if (a < 5'd17) return "R4";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [11:0] evt, input logic [12:0] cause, input logic rd,
                     input logic wr, input logic [4:0] a, input logic [31:0] wd,
                     input string tag);
    logic [11:0] clr;
    @(negedge clk);
    srcEvt = evt; abortCause = cause; busRd = rd; busWr = wr; busAddr = a; busWdata = wd;
    #1;
    if (rd) check((tag == "") ? tagOf(a) : tag, busRdata, expRead(a));
    @(posedge clk);
    clr  = clrOf(rd, a);
    irqM = |(rawM & maskM);
    rawM = ((evt | (rawM & ~clr)) & ~LVL) | (evt & LVL);
    if (evt[6])      reasonM = (clr[6] ? 13'd0 : reasonM) | cause;
    else if (clr[6]) reasonM = '0;
    if (wr && a == 5'd1) maskM = wd[11:0];
    #1;
    check("R10", {31'd0, irq}, {31'd0, irqM});
  endtask

  task automatic idleRead(input logic [4:0] a, input string tag);
    cyc('0, '0, 1'b1, 1'b0, a, '0, tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R11 reset state
    check("R11", {31'd0, irq}, 32'd0);
    idleRead(5'd0, "R11");
    idleRead(5'd1, "R11");
    idleRead(5'd3, "R11");
    idleRead(5'd20, "R11");

    // R2: write to non-enable word is ignored, then load enable
    cyc('0, '0, 1'b0, 1'b1, 5'd0, 32'hFFF, "R2");
    idleRead(5'd1, "R2");
    cyc('0, '0, 1'b0, 1'b1, 5'd1, 32'h0000_0A5F, "R2");
    idleRead(5'd1, "R2");

    // R1 sticky set from a pulse
    cyc(12'h200, '0, 1'b0, 1'b0, 5'd0, '0, "R1");
    idleRead(5'd0, "R1");
    idleRead(5'd0, "R1");
    idleRead(5'd2, "R3");

    // R6 event and acknowledge of bit 0 together
    cyc(12'h001, '0, 1'b1, 1'b0, 5'd5, '0, "R6");
    idleRead(5'd0, "R6");
    idleRead(5'd5, "R4");
    idleRead(5'd0, "R4");

    // R7 level sources ignore acknowledges
    cyc(12'h004, '0, 1'b0, 1'b0, 5'd0, '0, "R7");
    cyc(12'h004, '0, 1'b1, 1'b0, 5'd7, '0, "R7");
    cyc(12'h014, '0, 1'b1, 1'b0, 5'd0, '0, "R7");
    cyc('0, '0, 1'b1, 1'b0, 5'd4, '0, "R7");
    idleRead(5'd0, "R7");

    // R8 accumulate causes, R9 clear and same-cycle reload
    cyc(12'h040, 13'h1008, 1'b0, 1'b0, 5'd0, '0, "R8");
    cyc(12'h040, 13'h0001, 1'b0, 1'b0, 5'd0, '0, "R8");
    idleRead(5'd3, "R8");
    idleRead(5'd11, "R9");
    idleRead(5'd3, "R9");
    cyc(12'h040, 13'h0400, 1'b0, 1'b0, 5'd0, '0, "R8");
    cyc(12'h040, 13'h0010, 1'b1, 1'b1 ^ 1'b1, 5'd11, '0, "R9");
    idleRead(5'd3, "R9");
    idleRead(5'd0, "R9");

    // R5 acknowledge-all
    cyc(12'hFEB, '0, 1'b0, 1'b0, 5'd0, '0, "R5");
    idleRead(5'd4, "R5");
    idleRead(5'd0, "R5");
    idleRead(5'd3, "R9");
    idleRead(5'd4, "R5");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] e;
      logic        r, w;
      logic [4:0]  a;
      e = 12'($urandom & $urandom & $urandom);
      r = ($urandom % 2) == 0;
      w = !r && (($urandom % 6) == 0);
      a = 5'($urandom % 21);
      cyc(e, 13'($urandom), r, w, a, $urandom, "");
    end

    @(negedge clk);
    srcEvt = '0; busRd = 1'b0; busWr = 1'b0;
    finishRun();
  end
endmodule